// File: doc/BRIEF.md
# Supply-Qualified Memory Access Gate

This block stands between a memory controller and a non-volatile memory whose chip-select and write strobes must stay inactive (high) while the supply is unsafe. It watches two supply flags, both already synchronized to its clock. One says the rail is above the minimum operating level. The other says the rail has fallen under the lower threshold at which the memory blocks writes. From these flags it decides when the memory may be touched.

After reset, and after any dip under the lower threshold, the block holds both strobes high. It waits until the rail is back above the minimum. It then counts a full start-up delay, 2 ms by default, worked out from a clock-frequency parameter. Only after that does it raise a ready flag and pass the controller's strobes through unchanged. If the supply falters during the count, the count is discarded and starts again from zero. A dip under the lower threshold while ready removes access at the next clock edge. The ready flag is registered, so it never glitches.

Top module: `pwr_guard_seq`

## Requirements
- R1: While reset is asserted and after it is released, mem_ready is 0 and mem_ce_n and mem_we_n are 1, whatever ctl_ce_n and ctl_we_n are.
- R2: Whenever mem_ready is 0, mem_ce_n and mem_we_n are both 1 for every value of ctl_ce_n and ctl_we_n.
- R3: Whenever mem_ready is 1, mem_ce_n equals ctl_ce_n and mem_we_n equals ctl_we_n in the same cycle, with no clock delay.
- R4: From the inhibited state, mem_ready rises at the (WAIT_CYC+1)-th consecutive rising edge that samples vdd_ok=1 and vdd_low=0, and not earlier. WAIT_CYC is CLK_HZ*WAIT_US/1000000 cycles, with a minimum of 1.
- R5: If an edge during the start-up count samples vdd_ok=0, mem_ready stays 0 and the block returns to the inhibited state. The next start-up then needs the full WAIT_CYC+1 edges again.
- R6: Any edge that samples vdd_low=1, in any state, leaves mem_ready at 0 after that edge. When the flag clears and vdd_ok=1, the full WAIT_CYC+1 edge wait applies again.
- R7: In the inhibited state, vdd_ok=1 together with vdd_low=1 makes no progress: mem_ready stays 0 for as long as vdd_low stays 1.
- R8: While mem_ready is 1, vdd_ok falling to 0 with vdd_low still 0 (a rail between the two thresholds) keeps mem_ready at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_ok | input | 1 | Supply is above the minimum operating level (synchronized) |
| vdd_low | input | 1 | Supply is below the write-blocking threshold (synchronized) |
| ctl_ce_n | input | 1 | Chip enable from the memory controller, active low |
| ctl_we_n | input | 1 | Write enable from the memory controller, active low |
| mem_ce_n | output | 1 | Chip enable to the memory, forced high when not ready |
| mem_we_n | output | 1 | Write enable to the memory, forced high when not ready |
| mem_ready | output | 1 | Registered flag: memory may be accessed |

## Verification
Supply-flag results are due one clock edge after the edge that samples them. The exception is the end of the wait: mem_ready is due exactly WAIT_CYC+1 edges after the flags become good. The strobe outputs follow the controller strobes within the same cycle whenever the block is ready. The bench uses a small clock-frequency setting, so WAIT_CYC is 10. It changes inputs and checks outputs on the falling edge, and counts rising edges to get the expected ready value for every step of each start-up. It aborts a start-up at every possible count position, both by dropping vdd_ok and by raising vdd_low. After each abort it checks the full wait again, edge by edge.

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned WAIT_US = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vdd_ok,
  input  logic vdd_low,
  input  logic ctl_ce_n,
  input  logic ctl_we_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_ready
);
  localparam longint unsigned RAW = (longint'(CLK_HZ) * longint'(WAIT_US)) / 64'd1_000_000;
  localparam int unsigned WAIT_CYC = (RAW == 0) ? 1 : int'(RAW);
  localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  typedef enum logic [1:0] {S_INH, S_START, S_RUN} st_t;

  st_t state, nxt;
  logic [CW-1:0] cnt;
  logic ready_q;
  logic last;

  assign last = (cnt == CW'(WAIT_CYC - 1));

  always_comb begin
    nxt = state;
    case (state)
      S_INH:   if (vdd_ok && !vdd_low) nxt = S_START;
      S_START: if (!vdd_ok || vdd_low) nxt = S_INH;
               else if (last)          nxt = S_RUN;
      S_RUN:   if (vdd_low)            nxt = S_INH;
      default:                         nxt = S_INH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_INH;
      cnt     <= '0;
      ready_q <= 1'b0;
    end else begin
      state   <= nxt;
      cnt     <= (state == S_START && nxt == S_START) ? cnt + 1'b1 : '0;
      ready_q <= (nxt == S_RUN);
    end
  end

  assign mem_ready = ready_q;
  assign mem_ce_n  = ctl_ce_n | ~ready_q;
  assign mem_we_n  = ctl_we_n | ~ready_q;
endmodule

// File: rtl/pwr_guard_seq_chk.sv
module pwr_guard_seq_chk #(
  parameter int unsigned WAIT_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic vdd_ok,
  input logic vdd_low,
  input logic ctl_ce_n,
  input logic ctl_we_n,
  input logic mem_ce_n,
  input logic mem_we_n,
  input logic mem_ready
);
  logic [31:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run <= '0;
    else if (!vdd_ok || vdd_low) run <= '0;
    else if (run != 32'hFFFF_FFFF) run <= run + 32'd1;
  end

  always @(posedge clk)
    if (!rst_n) AST_RESET_QUIET: assert (!mem_ready && mem_ce_n && mem_we_n); // R1

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> (mem_ce_n && mem_we_n)); // R2
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |-> (mem_ce_n == ctl_ce_n && mem_we_n == ctl_we_n)); // R3
  AST_WAIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> (run == WAIT_CYC + 1)); // R4
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ready && !vdd_ok) |=> !mem_ready); // R5
  AST_BROWNOUT: assert property (@(posedge clk) disable iff (!rst_n)
    vdd_low |=> !mem_ready); // R6
  AST_MID_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ready && !vdd_low) |=> mem_ready); // R8
endmodule

bind pwr_guard_seq pwr_guard_seq_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .vdd_low(vdd_low),
  .ctl_ce_n(ctl_ce_n), .ctl_we_n(ctl_we_n),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_ready(mem_ready)
);

// File: tb/pwr_guard_seq_test.sv
`timescale 1ns/1ps
module pwr_guard_seq_test;
  localparam int unsigned HZ = 5000;
  localparam int unsigned US = 2000;
  localparam int W = (HZ * US) / 1_000_000;

  logic clk = 0, rst_n = 0, vdd_ok = 0, vdd_low = 1, ctl_ce_n = 0, ctl_we_n = 0;
  logic mem_ce_n, mem_we_n, mem_ready;
  int checks = 0, fails = 0;

  pwr_guard_seq #(.CLK_HZ(HZ), .WAIT_US(US)) uut (
    .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .vdd_low(vdd_low),
    .ctl_ce_n(ctl_ce_n), .ctl_we_n(ctl_we_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_ready(mem_ready));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // R4 / R2: full wait counted from the inhibited state
  task automatic startup_expect(input string tag);
    vdd_ok = 1; vdd_low = 0; ctl_ce_n = 0; ctl_we_n = 0;
    for (int i = 1; i <= W + 1; i++) begin
      tick(1);
      chk(tag, mem_ready, i == W + 1);
      if (i <= W) chk("R2 forced ce", mem_ce_n, 1'b1);
    end
  endtask

  initial begin
    tick(2);
    chk("R1 ready", mem_ready, 1'b0);
    chk("R1 ce", mem_ce_n, 1'b1);
    chk("R1 we", mem_we_n, 1'b1);
    rst_n = 1;
    tick(1);
    chk("R1 after release", mem_ready, 1'b0);

    vdd_ok = 1; vdd_low = 1;
    for (int i = 0; i < 2 * W; i++) begin
      tick(1);
      chk("R7 stalled", mem_ready, 1'b0);
    end

    for (int v = 0; v < 4; v++) begin
      {ctl_ce_n, ctl_we_n} = v[1:0]; #1;
      chk("R2 ce", mem_ce_n, 1'b1);
      chk("R2 we", mem_we_n, 1'b1);
    end

    startup_expect("R4 first start");

    for (int v = 0; v < 4; v++) begin
      {ctl_ce_n, ctl_we_n} = v[1:0]; #1;
      chk("R3 ce", mem_ce_n, v[1]);
      chk("R3 we", mem_we_n, v[0]);
    end

    vdd_ok = 0; vdd_low = 0;
    for (int i = 0; i < 5; i++) begin
      tick(1);
      chk("R8 mid rail", mem_ready, 1'b1);
    end

    ctl_ce_n = 0; ctl_we_n = 0; vdd_low = 1;
    tick(1);
    chk("R6 brownout ready", mem_ready, 1'b0);
    chk("R6 brownout ce", mem_ce_n, 1'b1);
    chk("R6 brownout we", mem_we_n, 1'b1);
    startup_expect("R6 rearm");

    for (int k = 1; k <= W; k++) begin
      vdd_low = 1; tick(1); vdd_low = 0; vdd_ok = 0; tick(1);
      vdd_ok = 1;
      for (int i = 0; i < k; i++) begin
        tick(1);
        chk("R5 counting", mem_ready, 1'b0);
      end
      vdd_ok = 0; tick(1);
      chk("R5 abort", mem_ready, 1'b0);
      tick(1);
      chk("R5 abort hold", mem_ready, 1'b0);
      startup_expect("R5 restart");
    end

    for (int k = 1; k <= W; k++) begin
      vdd_low = 1; tick(1); vdd_low = 0; vdd_ok = 0; tick(1);
      vdd_ok = 1;
      tick(k);
      vdd_low = 1; tick(1);
      chk("R6 dip in start", mem_ready, 1'b0);
      startup_expect("R6 restart");
    end

    summary();
  end

  initial begin
    repeat (100_000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected done");
    summary();
  end
endmodule